// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block gathers a vector of raw interrupt inputs, split into banks of 32, and turns them into one interrupt request line and a readable source number. Every bank offers four word registers on a simple 32-bit register bus: a latched event view, an enable mask, an acknowledge port and a live level view. Inputs pass through a synchronizer first. Most bits are edge-type: a rising edge sets the matching latched event bit, which stays set until software acknowledges it. A fixed set of bits is level-type and is not latched. Those bits count as pending for as long as the synchronized input stays high.

A source is pending when it is enabled and either its event bit is set or it is a level-type bit that is high. The interrupt output is the registered OR of every pending source. A vector register at its own address names the highest-numbered pending source. Software enables a source, takes the interrupt, reads the vector, acknowledges edge sources, and clears the cause of level sources at the device.

Top module: `birq_ctrl`

## Requirements
- R1: After reset every enable register and every event register reads 0, the interrupt output is low, and the vector register reads 0xFF.
- R2: Bank 0 (sources 0–31) has its base at byte address 0x20 and bank 1 (sources 32–63) at 0x10. Within a bank, the event register is at +0x0, enable at +0x4, ack at +0x8 and level at +0xC. The vector register is at 0x30. The ack register and any unmapped address read as 0.
- R3: A rising edge on an edge-type input sets its event bit, visible on a read taken after the third clock edge that follows the input change. The bit then stays set, whether or not the source is enabled, until it is acknowledged.
- R4: Writing the ack register clears every event bit that has a 1 in the written word. Bits written as 0 keep their state.
- R5: Bits 20 to 29 of bank 0 are level-type and never set an event bit. The level register of each bank returns the synchronized live state of all 32 inputs, enabled or not.
- R6: A bank's pending set is (event OR (live AND level-type mask)) AND enable. The interrupt output equals the OR of all pending bits, delayed by one register.
- R7: Setting an enable bit while the input is already high, with no new rising edge, neither sets the event bit nor raises the interrupt output for an edge-type source.
- R8: The vector register returns, in its low 8 bits, the highest-numbered pending source across all banks, or 0xFF when nothing is pending.
- R9: When a rising edge reaches an event bit in the same cycle as an ack write to that bit, the bit ends up set.
- R10: Writes to an event register, a level register or the vector register change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 64 | Raw interrupt inputs, bit n is source n |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench uses the default build: two banks of 32 sources, a two-stage synchronizer, and level-type bits 20–29 in bank 0 only. Both banks are covered, so the search from bank 1 down to bank 0 in the vector register is exercised. Bank 1 bits 20–29 serve as edge-type controls for the level range of bank 0. The two synchronizer stages fix when an edge reaches the event register. The bench uses that timing to line up an ack write with an arriving edge in the same cycle.

// File: rtl/birq_pkg.sv
package birq_pkg;
  // Word slot inside a bank, taken from address bits [3:2].
  typedef enum logic [1:0] {
    SLOT_EVENT  = 2'd0,
    SLOT_ENABLE = 2'd1,
    SLOT_ACK    = 2'd2,
    SLOT_LEVEL  = 2'd3
  } bank_slot_e;

  localparam int unsigned VEC_W = 8;
endpackage

// File: rtl/birq_sync.sv
module birq_sync #(
  parameter int unsigned W      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = din;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/birq_bank.sv
module birq_bank #(
  parameter int unsigned   W     = 32,
  parameter logic [W-1:0]  LMASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live,
  input  logic         en_wr,
  input  logic         ack_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] event_q,
  output logic [W-1:0] enable_q,
  output logic [W-1:0] rise,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q;
  logic [W-1:0] event_d;
  logic [W-1:0] ack_bits;
  logic         event_ce;

  // Edge-type bits only; level-type bits never latch.
  assign rise     = live & ~prev_q & ~LMASK;
  assign ack_bits = ack_wr ? wdata : '0;
  assign event_ce = ack_wr | (|rise);

  always_comb begin
    // A new edge wins over an ack of the same bit.
    event_d = (event_q & ~ack_bits) | rise;
  end

  assign pend = (event_q | (live & LMASK)) & enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        event_q <= '0;
    else if (event_ce) event_q <= event_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable_q <= '0;
    else if (en_wr) enable_q <= wdata;
  end
endmodule

// File: rtl/birq_prio.sv
module birq_prio #(
  parameter int unsigned N     = 64,
  parameter int unsigned OUT_W = 8
) (
  input  logic [N-1:0]     pend,
  output logic [OUT_W-1:0] vec
);
  // Ascending scan: the last hit is the highest index.
  always_comb begin
    vec = '1;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) vec = OUT_W'(i);
    end
  end
endmodule

// File: rtl/birq_ctrl.sv
module birq_ctrl #(
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned BANK_W        = 32,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter logic [7:0]  TOP_BANK_BASE = 8'h20,
  parameter logic [7:0]  BANK_STRIDE   = 8'h10,
  parameter logic [7:0]  VEC_ADDR      = 8'h30,
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_MASK = 64'h0000_0000_3FF0_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] src_in,
  output logic                        irq_out
);
  import birq_pkg::*;

  localparam int unsigned NSRC = NUM_BANKS * BANK_W;

  logic [NSRC-1:0]   live_all;
  logic [NSRC-1:0]   event_all;
  logic [NSRC-1:0]   enable_all;
  logic [NSRC-1:0]   rise_all;
  logic [NSRC-1:0]   pend_all;
  logic [VEC_W-1:0]  vec;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [BANK_W-1:0] bank_rd [NUM_BANKS];
  bank_slot_e        slot;
  logic              irq_q;

  assign slot = bank_slot_e'(bus_addr[3:2]);

  birq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (src_in),
    .dout (live_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] BASE =
      ADDR_W'(TOP_BANK_BASE) - ADDR_W'(b) * ADDR_W'(BANK_STRIDE);
    logic [BANK_W-1:0] ev_q, en_q;

    assign bank_hit[b] = (bus_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);

    birq_bank #(
      .W    (BANK_W),
      .LMASK(LEVEL_MASK[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .live    (live_all[b*BANK_W +: BANK_W]),
      .en_wr   (bus_wr && bank_hit[b] && slot == SLOT_ENABLE),
      .ack_wr  (bus_wr && bank_hit[b] && slot == SLOT_ACK),
      .wdata   (bus_wdata),
      .event_q (ev_q),
      .enable_q(en_q),
      .rise    (rise_all[b*BANK_W +: BANK_W]),
      .pend    (pend_all[b*BANK_W +: BANK_W])
    );

    assign event_all[b*BANK_W +: BANK_W]  = ev_q;
    assign enable_all[b*BANK_W +: BANK_W] = en_q;

    always_comb begin
      case (slot)
        SLOT_EVENT:  bank_rd[b] = ev_q;
        SLOT_ENABLE: bank_rd[b] = en_q;
        SLOT_LEVEL:  bank_rd[b] = live_all[b*BANK_W +: BANK_W];
        default:     bank_rd[b] = '0;
      endcase
    end
  end

  birq_prio #(.N(NSRC), .OUT_W(VEC_W)) u_prio (
    .pend(pend_all),
    .vec (vec)
  );

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) bus_rdata = bank_rd[b];
    end
    if (bus_addr == ADDR_W'(VEC_ADDR)) bus_rdata = BANK_W'(vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend_all;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/birq_ctrl_chk.sv
module birq_ctrl_chk #(
  parameter int unsigned    NSRC       = 64,
  parameter logic [NSRC-1:0] LEVEL_MASK = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            irq_out,
  input logic [NSRC-1:0] pend_all,
  input logic [NSRC-1:0] event_all,
  input logic [NSRC-1:0] enable_all,
  input logic [NSRC-1:0] rise_all
);
  p_irq_tracks_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|pend_all));

  p_quiet_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable_all) == '0) |-> !irq_out);

  p_event_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (($past(event_all) & ~event_all) == '0));

  p_edge_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_all != '0) |=> ((event_all & $past(rise_all)) == $past(rise_all)));

  p_level_unlatched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (event_all & LEVEL_MASK) == '0);
endmodule

bind birq_ctrl birq_ctrl_chk #(.NSRC(NSRC), .LEVEL_MASK(LEVEL_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .irq_out   (irq_out),
  .pend_all  (pend_all),
  .event_all (event_all),
  .enable_all(enable_all),
  .rise_all  (rise_all)
);

// File: tb/birq_ctrl_tb.sv
module birq_ctrl_tb;
  localparam real HALF = 2.5;
  localparam logic [63:0] LM = 64'h0000_0000_3FF0_0000;
  localparam logic [7:0] B0 = 8'h20, B1 = 8'h10, VA = 8'h30;
  localparam logic [7:0] O_EV = 8'h0, O_EN = 8'h4, O_ACK = 8'h8, O_LV = 8'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  birq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] top_vec(input logic [63:0] p);
    logic [31:0] v = 32'hFF;
    for (int i = 0; i < 64; i++) if (p[i]) v = i;
    return v;
  endfunction

  task automatic clear_all();
    wr(B0 + O_ACK, 32'hFFFF_FFFF);
    wr(B1 + O_ACK, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] r, en, ev, pd;
    void'($urandom(32'd4711));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    rd(B0 + O_EN, d); check("R1 enable0", d, 0);
    rd(B1 + O_EN, d); check("R1 enable1", d, 0);
    rd(B0 + O_EV, d); check("R1 event0", d, 0);
    rd(VA, d);        check("R1 vector", d, 32'hFF);
    check("R1 irq", irq_out, 0);

    // R2 map: enable readback at both bases, ack and unmapped read 0
    wr(B0 + O_EN, 32'h1234_5678); wr(B1 + O_EN, 32'h9ABC_DEF0);
    rd(B0 + O_EN, d); check("R2 bank0 enable", d, 32'h1234_5678);
    rd(B1 + O_EN, d); check("R2 bank1 enable", d, 32'h9ABC_DEF0);
    rd(B0 + O_ACK, d); check("R2 ack reads 0", d, 0);
    rd(8'h00, d);      check("R2 unmapped", d, 0);
    wr(B0 + O_EN, 0); wr(B1 + O_EN, 0);

    // R7 / R3: edge while disabled latches; ack; then enable with input high
    @(negedge clk); src_in[5] = 1'b1;
    wait_n(3);
    rd(B0 + O_EV, d); check("R3 latched while disabled", d, 32'h20);
    check("R3 no irq when disabled", irq_out, 0);
    wr(B0 + O_ACK, 32'h20);
    wr(B0 + O_EN, 32'h20);
    wait_n(3);
    rd(B0 + O_EV, d); check("R7 enable no event", d, 0);
    check("R7 enable no irq", irq_out, 0);
    rd(VA, d); check("R7 vector idle", d, 32'hFF);
    @(negedge clk); src_in[5] = 1'b0;
    wait_n(3);

    // R4 partial ack and zero ack
    @(negedge clk); src_in[3] = 1'b1; src_in[7] = 1'b1;
    wait_n(4);
    wr(B0 + O_ACK, 32'h0);
    rd(B0 + O_EV, d); check("R4 zero ack keeps", d, 32'h88);
    wr(B0 + O_ACK, 32'h8);
    rd(B0 + O_EV, d); check("R4 partial ack", d, 32'h80);
    clear_all();

    // R9 edge and ack in same cycle
    @(negedge clk); src_in[40] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = B1 + O_ACK; bus_wdata = 32'h100;
    @(negedge clk); bus_wr = 1'b0;
    rd(B1 + O_EV, d); check("R9 edge beats ack", d, 32'h100);

    // R10 writes to read-only locations ignored
    wr(B1 + O_EV, 32'h0); wr(B0 + O_EV, 32'hFFFF_FFFF);
    wr(B0 + O_LV, 32'hFFFF_FFFF); wr(VA, 32'h0);
    rd(B1 + O_EV, d); check("R10 event write ignored b1", d, 32'h100);
    rd(B0 + O_EV, d); check("R10 event write ignored b0", d, 32'h0);
    rd(B0 + O_EN, d); check("R10 enable untouched", d, 32'h20);
    clear_all();
    src_in = '0; wait_n(4);

    // R5/R6 level source bit 25 of bank 0
    wr(B0 + O_EN, 32'h0200_0000);
    @(negedge clk); src_in[25] = 1'b1;
    wait_n(3);
    check("R6 level irq", irq_out, 1);
    rd(B0 + O_EV, d); check("R5 level no latch", d, 0);
    rd(B0 + O_LV, d); check("R5 level view", d, 32'h0200_0000);
    rd(VA, d); check("R8 level vector", d, 25);
    @(negedge clk); src_in[25] = 1'b0;
    wait_n(3);
    check("R6 level irq drops", irq_out, 0);
    // bank1 bit 20 is edge-type
    @(negedge clk); src_in[52] = 1'b1;
    wait_n(3);
    rd(B1 + O_EV, d); check("R5 bank1 bit20 edge", d, 32'h0010_0000);
    src_in = '0; clear_all(); wait_n(4);

    // Random patterns: R3 R5 R6 R8
    for (int it = 0; it < 40; it++) begin
      r  = {$urandom(), $urandom()};
      en = {$urandom(), $urandom()};
      if (it % 4 == 0) en = '0;
      wr(B0 + O_EN, en[31:0]); wr(B1 + O_EN, en[63:32]);
      @(negedge clk); src_in = r;
      wait_n(4);
      ev = r & ~LM;
      pd = (ev | (r & LM)) & en;
      rd(B0 + O_EV, d); check("R3 random event0", d, ev[31:0]);
      rd(B1 + O_EV, d); check("R3 random event1", d, ev[63:32]);
      rd(B0 + O_LV, d); check("R5 random level0", d, r[31:0]);
      rd(B1 + O_LV, d); check("R5 random level1", d, r[63:32]);
      rd(VA, d);        check("R8 random vector", d, top_vec(pd));
      check("R6 random irq", irq_out, |pd);
      clear_all();
      @(negedge clk); src_in = '0;
      wait_n(4);
    end

    // R8 highest wins across banks
    wr(B0 + O_EN, 32'h4); wr(B1 + O_EN, 32'h8000_0000);
    @(negedge clk); src_in[2] = 1'b1; src_in[63] = 1'b1;
    wait_n(4);
    rd(VA, d); check("R8 top source", d, 63);
    wr(B1 + O_ACK, 32'h8000_0000);
    rd(VA, d); check("R8 next source", d, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule